// File: doc/BRIEF.md
# Flash Block Erase-Verify Sequencer

This controller clears selected blocks of an on-chip flash array and confirms every erase before it moves on. Software or a higher-level controller issues a single start pulse with a bit mask of the blocks it wants cleared. The sequencer then works through those blocks one at a time, from the lowest set bit upward. For each block it drives a one-hot select to the array, holds the erase-enable line high for a programmed number of cycles, and then checks every word of the block.

The erase pulse is applied directly, with no prior write of zeros. A watchdog bounds the time the erase-enable line may stay high. Each word is checked with the same pair of steps: a dummy byte write of 0xFF to an even address, then a 16-bit read from that same address. A single word that does not read all ones sends the block back for another erase and a fresh verify walk. After a fixed number of passes the sequencer gives up, reports the block and abandons the rest of the request.

An interrupt-mask output stays high for the whole sequence, so the array is never interrupted mid-operation.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the block is idle with every output low. A start_i pulse with a non-zero mask is taken only while idle, and busy_o is high from the next cycle on. A start_i seen while busy_o is high has no effect on the blocks erased or on the timing.
- R2: Blocks are handled one at a time in ascending index order. fl_blk_sel_o never has more than one bit set, and it has exactly one bit set whenever fl_erase_o is high.
- R3: The first flash action on each newly selected block is the erase pulse. No dummy write reaches a block before it has been erased once.
- R4: When erase_cycles_i lies between 1 and WDT_CYCLES, fl_erase_o stays high for exactly erase_cycles_i consecutive cycles on every pass.
- R5: When erase_cycles_i is larger than WDT_CYCLES, fl_erase_o drops after WDT_CYCLES cycles. busy_o then falls, err_o=1, err_wdt_o=1, err_blk_o holds the block index, and the remaining blocks are skipped.
- R6: Verify walks the block's words in ascending order. Block b, word k uses byte address b*BLOCK_WORDS*2+2k, which is always even. Each word takes one cycle of fl_wr_o with fl_wdata_o=0xFF, followed in the next cycle by fl_rd_o at the same address.
- R7: A word passes only if it reads 0xFFFF. The first word that reads any other value ends the walk and starts a new erase of the same block, and the next walk begins again at the block's first word.
- R8: At most MAX_PASSES erase passes are made per block. If the last verify walk still fails, busy_o falls with err_o=1, err_wdt_o=0, err_blk_o set to the block, and the remaining blocks are skipped.
- R9: irq_mask_o is high in every cycle busy_o is high and in the one cycle after busy_o falls, and low afterwards.
- R10: On success, done_o is high for exactly the first cycle in which busy_o is low, with err_o=0 and fl_blk_sel_o all zero.
- R11: A start_i with an all-zero mask raises done_o in the next cycle. busy_o and irq_mask_o stay low, and err_o stays 0.
- R12: err_o, err_wdt_o and err_blk_o hold their values until the next accepted start_i, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| blk_mask_i | input | NUM_BLOCKS | Blocks to erase, one bit per block |
| erase_cycles_i | input | LEN_W | Length of each erase pulse in cycles |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | Sequence aborted on a fault |
| err_wdt_o | output | 1 | Fault cause: 1 for watchdog, 0 for pass limit |
| err_blk_o | output | $clog2(NUM_BLOCKS) | Index of the block that faulted |
| irq_mask_o | output | 1 | Interrupt mask held over the sequence |
| fl_blk_sel_o | output | NUM_BLOCKS | One-hot block select to the array |
| fl_erase_o | output | 1 | Erase enable to the array |
| fl_wr_o | output | 1 | Dummy write strobe |
| fl_rd_o | output | 1 | Verify read strobe |
| fl_addr_o | output | ADDR_W | Byte address for write and read |
| fl_wdata_o | output | 8 | Dummy write data |
| fl_rdata_i | input | 16 | Verify read word, valid in the fl_rd_o cycle |

## Verification
busy_o rises one cycle after the accepted start. From then on it stays high for a number of cycles that follows from the requirements. Each block costs 1 selection cycle, plus one erase pulse per pass, plus two cycles per checked word; a failing walk stops at its first bad word. On a watchdog fault the failing block costs 1 plus WDT_CYCLES. The bench adds these terms up, counts busy cycles at falling edges, and compares the two. It then samples done_o, the error outputs and irq_mask_o in the first idle cycle, and irq_mask_o and done_o again one cycle later. Pulse lengths, block order and the write-then-read pairing are tracked cycle by cycle against the flash model, which answers reads combinationally in the fl_rd_o cycle.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_ERASE,
    ST_VWRITE,
    ST_VREAD
  } fe_state_e;
endpackage

// File: rtl/flash_blk_pick.sv
module flash_blk_pick #(
  parameter  int NB    = 4,
  localparam int IDX_W = $clog2(NB)
) (
  input  logic [NB-1:0]    req_i,
  output logic [NB-1:0]    oh_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [NB-1:0] below;
  assign below[0] = 1'b0;

  for (genvar i = 0; i < NB; i++) begin : g_pick
    assign oh_o[i] = req_i[i] & ~below[i];
    if (i < NB - 1) begin : g_chain
      assign below[i+1] = below[i] | req_i[i];
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
  parameter int LEN_W      = 20,
  parameter int WDT_CYCLES = 198000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             len_hit_o,
  output logic             wdt_ovf_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + LEN_W'(1);
    else            cnt_q <= '0;
  end

  // a length of zero behaves as one cycle
  assign len_hit_o = run_i && ((cnt_q + LEN_W'(1)) >= len_i);
  assign wdt_ovf_o = run_i && (cnt_q == LEN_W'(WDT_CYCLES - 1));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter  int NUM_BLOCKS  = 4,
  parameter  int BLOCK_WORDS = 8,
  parameter  int LEN_W       = 20,
  parameter  int WDT_CYCLES  = 198000,
  parameter  int MAX_PASSES  = 100,
  localparam int IDX_W       = $clog2(NUM_BLOCKS),
  localparam int WOFF_W      = $clog2(BLOCK_WORDS),
  localparam int ADDR_W      = IDX_W + WOFF_W + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [NUM_BLOCKS-1:0] blk_mask_i,
  input  logic [LEN_W-1:0]      erase_cycles_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  err_o,
  output logic                  err_wdt_o,
  output logic [IDX_W-1:0]      err_blk_o,
  output logic                  irq_mask_o,
  output logic [NUM_BLOCKS-1:0] fl_blk_sel_o,
  output logic                  fl_erase_o,
  output logic                  fl_wr_o,
  output logic                  fl_rd_o,
  output logic [ADDR_W-1:0]     fl_addr_o,
  output logic [7:0]            fl_wdata_o,
  input  logic [15:0]           fl_rdata_i
);
  localparam int PASS_W = $clog2(MAX_PASSES + 1);

  fe_state_e             state_q;
  logic [NUM_BLOCKS-1:0] pend_q, sel_q, pick_oh;
  logic [IDX_W-1:0]      idx_q, pick_idx, err_blk_q;
  logic [WOFF_W-1:0]     woff_q;
  logic [PASS_W-1:0]     pass_q;
  logic                  done_q, err_q, err_wdt_q, hold_q;
  logic                  len_hit, wdt_ovf, word_ok, last_word;

  flash_blk_pick #(.NB(NUM_BLOCKS)) u_pick (
    .req_i (pend_q),
    .oh_o  (pick_oh),
    .idx_o (pick_idx)
  );

  flash_erase_timer #(.LEN_W(LEN_W), .WDT_CYCLES(WDT_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state_q == ST_ERASE),
    .len_i     (erase_cycles_i),
    .len_hit_o (len_hit),
    .wdt_ovf_o (wdt_ovf)
  );

  assign word_ok   = (fl_rdata_i == 16'hFFFF);
  assign last_word = (woff_q == WOFF_W'(BLOCK_WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pend_q    <= '0;
      sel_q     <= '0;
      idx_q     <= '0;
      woff_q    <= '0;
      pass_q    <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      err_wdt_q <= 1'b0;
      err_blk_q <= '0;
      hold_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      hold_q <= (state_q != ST_IDLE);
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            err_q     <= 1'b0;
            err_wdt_q <= 1'b0;
            err_blk_q <= '0;
            if (|blk_mask_i) begin
              pend_q  <= blk_mask_i;
              state_q <= ST_SELECT;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
        ST_SELECT: begin
          sel_q   <= pick_oh;
          idx_q   <= pick_idx;
          pend_q  <= pend_q & ~pick_oh;
          pass_q  <= '0;
          woff_q  <= '0;
          state_q <= ST_ERASE;
        end
        ST_ERASE: begin
          if (len_hit) begin
            woff_q  <= '0;
            state_q <= ST_VWRITE;
          end else if (wdt_ovf) begin
            state_q   <= ST_IDLE;
            err_q     <= 1'b1;
            err_wdt_q <= 1'b1;
            err_blk_q <= idx_q;
            sel_q     <= '0;
            pend_q    <= '0;
          end
        end
        ST_VWRITE: state_q <= ST_VREAD;
        ST_VREAD: begin
          if (word_ok) begin
            if (!last_word) begin
              woff_q  <= woff_q + WOFF_W'(1);
              state_q <= ST_VWRITE;
            end else if (|pend_q) begin
              state_q <= ST_SELECT;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              sel_q   <= '0;
            end
          end else if (pass_q == PASS_W'(MAX_PASSES - 1)) begin
            state_q   <= ST_IDLE;
            err_q     <= 1'b1;
            err_wdt_q <= 1'b0;
            err_blk_q <= idx_q;
            sel_q     <= '0;
            pend_q    <= '0;
          end else begin
            pass_q  <= pass_q + PASS_W'(1);
            state_q <= ST_ERASE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign irq_mask_o   = busy_o | hold_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign err_wdt_o    = err_wdt_q;
  assign err_blk_o    = err_blk_q;
  assign fl_blk_sel_o = sel_q;
  assign fl_erase_o   = (state_q == ST_ERASE);
  assign fl_wr_o      = (state_q == ST_VWRITE);
  assign fl_rd_o      = (state_q == ST_VREAD);
  assign fl_addr_o    = {idx_q, woff_q, 1'b0};
  assign fl_wdata_o   = 8'hFF;
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk #(
  parameter int NB         = 4,
  parameter int LEN_W      = 20,
  parameter int WDT_CYCLES = 198000,
  parameter int ADDR_W     = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              irq_mask_o,
  input logic [NB-1:0]     fl_blk_sel_o,
  input logic              fl_erase_o,
  input logic              fl_wr_o,
  input logic              fl_rd_o,
  input logic [ADDR_W-1:0] fl_addr_o,
  input logic [7:0]        fl_wdata_o
);
  logic [LEN_W-1:0] e_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         e_run_q <= '0;
    else if (fl_erase_o) e_run_q <= e_run_q + LEN_W'(1);
    else                 e_run_q <= '0;
  end

  assert_sel_onehot0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fl_blk_sel_o));
  assert_sel_during_erase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_erase_o |-> ($countones(fl_blk_sel_o) == 1) && busy_o);
  assert_wdt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_erase_o |-> (e_run_q < LEN_W'(WDT_CYCLES)));
  assert_dummy_byte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_wr_o |-> (fl_wdata_o == 8'hFF) && !fl_addr_o[0]);
  assert_wr_then_rd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_wr_o |=> fl_rd_o && (fl_addr_o == $past(fl_addr_o)));
  assert_irq_cover_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> irq_mask_o);
  assert_irq_tail_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> irq_mask_o);
  assert_done_clean_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !err_o && (fl_blk_sel_o == '0));
  assert_err_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o);
endmodule

bind flash_erase_seq flash_erase_seq_chk #(
  .NB(NUM_BLOCKS), .LEN_W(LEN_W), .WDT_CYCLES(WDT_CYCLES), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB         = 4;
  localparam int BW         = 4;
  localparam int LEN_W      = 20;
  localparam int WDT        = 40;
  localparam int MP         = 100;
  localparam int IDX_W      = $clog2(NB);
  localparam int WOFF_W     = $clog2(BW);
  localparam int ADDR_W     = IDX_W + WOFF_W + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [NB-1:0]     blk_mask = '0;
  logic [LEN_W-1:0]  ecyc = '0;
  logic              busy, done, err, err_wdt, irq_mask;
  logic [IDX_W-1:0]  err_blk;
  logic [NB-1:0]     fl_sel;
  logic              fl_erase, fl_wr, fl_rd;
  logic [ADDR_W-1:0] fl_addr;
  logic [7:0]        fl_wdata;
  logic [15:0]       fl_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_seq #(
    .NUM_BLOCKS(NB), .BLOCK_WORDS(BW), .LEN_W(LEN_W), .WDT_CYCLES(WDT), .MAX_PASSES(MP)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .blk_mask_i(blk_mask),
    .erase_cycles_i(ecyc), .busy_o(busy), .done_o(done), .err_o(err),
    .err_wdt_o(err_wdt), .err_blk_o(err_blk), .irq_mask_o(irq_mask),
    .fl_blk_sel_o(fl_sel), .fl_erase_o(fl_erase), .fl_wr_o(fl_wr), .fl_rd_o(fl_rd),
    .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata), .fl_rdata_i(fl_rdata)
  );

  // flash model: a block reads clean once erased need[] times; before that,
  // words from bad[] onward read bval[]
  int          ecnt[NB];
  int          need[NB];
  int          bad[NB];
  logic [15:0] bval[NB];
  int          ab, aw;
  assign ab = int'(fl_addr >> (WOFF_W + 1));
  assign aw = int'(fl_addr[WOFF_W:1]);
  always_comb begin
    fl_rdata = 16'hFFFF;
    if (ecnt[ab] < need[ab] && aw >= bad[ab]) fl_rdata = bval[ab];
  end

  int nchk = 0, nfail = 0;
  // monitor state
  logic              prev_e, prev_wr;
  logic [ADDR_W-1:0] prev_addr;
  logic [NB-1:0]     prev_sel;
  int erun, cur_blk, norder, bad_elen, v_pre, v_ver, v_irq, v_sel, exp_elen;
  bit erased_flag;
  int order[8];
  // expectation
  int exp_cyc, exp_blk, exp_norder;
  bit exp_err, exp_wdt;
  int exp_order[8];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int oh2idx(logic [NB-1:0] v);
    int r = 0;
    for (int i = 0; i < NB; i++) if (v[i]) r = i;
    return r;
  endfunction

  task automatic step();
    @(negedge clk);
    if (fl_sel != prev_sel) erased_flag = 0;
    if (fl_erase) begin
      if (!prev_e) begin
        cur_blk = oh2idx(fl_sel);
        erased_flag = 1;
        if (norder == 0 || order[(norder-1) % 8] != cur_blk) begin
          if (norder < 8) order[norder] = cur_blk;
          norder++;
        end
      end
      erun++;
      if ($countones(fl_sel) != 1) v_sel++;
    end else if (prev_e) begin
      if (erun != exp_elen) bad_elen++;
      ecnt[cur_blk]++;
      erun = 0;
    end
    if (fl_wr) begin
      if (!erased_flag) v_pre++;
      if (fl_wdata != 8'hFF || fl_addr[0]) v_ver++;
    end
    if (prev_wr && !(fl_rd && fl_addr == prev_addr)) v_ver++;
    if (busy && !irq_mask) v_irq++;
    prev_e = fl_erase; prev_wr = fl_wr; prev_addr = fl_addr; prev_sel = fl_sel;
  endtask

  task automatic compute(logic [NB-1:0] m, int len);
    int passes;
    exp_cyc = 0; exp_err = 0; exp_wdt = 0; exp_blk = 0; exp_norder = 0;
    exp_elen = (len > WDT) ? WDT : ((len < 1) ? 1 : len);
    for (int b = 0; b < NB; b++) begin
      if (m[b] && !exp_err) begin
        exp_order[exp_norder] = b;
        exp_norder++;
        passes = (need[b] < 1) ? 1 : need[b];
        if (len > WDT) begin
          exp_cyc += 1 + WDT; exp_err = 1; exp_wdt = 1; exp_blk = b;
        end else if (passes > MP) begin
          exp_cyc += 1 + MP * exp_elen + MP * 2 * (bad[b] + 1);
          exp_err = 1; exp_blk = b;
        end else begin
          exp_cyc += 1 + passes * exp_elen + (passes - 1) * 2 * (bad[b] + 1) + 2 * BW;
        end
      end
    end
  endtask

  task automatic run_op(logic [NB-1:0] m, int len, bit poke);
    int cnt;
    for (int b = 0; b < NB; b++) ecnt[b] = 0;
    norder = 0; bad_elen = 0; v_pre = 0; v_ver = 0; v_irq = 0; v_sel = 0; erun = 0;
    compute(m, len);
    start = 1'b1; blk_mask = m; ecyc = LEN_W'(len);
    step();
    start = 1'b0; blk_mask = '0;
    chk(busy == 1'b1, "R1", "busy after start", int'(busy), 1);
    chk(err == 1'b0, "R12", "err cleared by start", int'(err), 0);
    cnt = 1;
    while (busy && cnt < 60000) begin
      if (poke && cnt == 3) begin start = 1'b1; blk_mask = '1; end
      else begin start = 1'b0; blk_mask = '0; end
      step();
      if (busy) cnt++;
    end
    start = 1'b0; blk_mask = '0;
    chk(cnt == exp_cyc, "R7", "busy cycle count", cnt, exp_cyc);
    chk(done == !exp_err, "R10", "done pulse", int'(done), int'(!exp_err));
    chk(err == exp_err, "R8", "err flag", int'(err), int'(exp_err));
    if (exp_err) begin
      chk(err_blk == IDX_W'(exp_blk), "R5", "failing block", int'(err_blk), exp_blk);
      chk(err_wdt == exp_wdt, "R5", "watchdog cause", int'(err_wdt), int'(exp_wdt));
    end
    chk(fl_sel == '0, "R10", "select cleared", int'(fl_sel), 0);
    chk(irq_mask == 1'b1, "R9", "mask tail cycle", int'(irq_mask), 1);
    chk(norder == exp_norder, "R2", "blocks erased", norder, exp_norder);
    for (int i = 0; i < exp_norder && i < norder && i < 8; i++)
      chk(order[i] == exp_order[i], "R2", "block order", order[i], exp_order[i]);
    chk(bad_elen == 0, "R4", "erase pulse length errors", bad_elen, 0);
    chk(v_pre == 0, "R3", "write before erase", v_pre, 0);
    chk(v_ver == 0, "R6", "verify pairing errors", v_ver, 0);
    chk(v_irq == 0, "R9", "mask gaps while busy", v_irq, 0);
    chk(v_sel == 0, "R2", "select not one-hot in erase", v_sel, 0);
    step();
    chk(irq_mask == 1'b0, "R9", "mask released", int'(irq_mask), 0);
    chk(done == 1'b0, "R10", "done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    prev_e = 0; prev_wr = 0; prev_addr = '0; prev_sel = '0; erased_flag = 0;
    erun = 0; cur_blk = 0; norder = 0; exp_elen = 1;
    for (int b = 0; b < NB; b++) begin
      ecnt[b] = 0; need[b] = 1; bad[b] = 0; bval[b] = 16'h0000;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk({busy, done, err, irq_mask, fl_erase, fl_wr, fl_rd} == 7'b0, "R1", "idle outputs",
        int'({busy, done, err, irq_mask, fl_erase, fl_wr, fl_rd}), 0);
    chk(fl_sel == '0, "R1", "idle select", int'(fl_sel), 0);

    // R11 empty mask
    start = 1'b1; blk_mask = '0; ecyc = LEN_W'(5);
    step();
    start = 1'b0;
    chk(done == 1'b1, "R11", "empty mask done", int'(done), 1);
    chk(busy == 1'b0, "R11", "empty mask busy", int'(busy), 0);
    chk(irq_mask == 1'b0, "R11", "empty mask irq", int'(irq_mask), 0);
    chk(err == 1'b0, "R11", "empty mask err", int'(err), 0);
    step();
    chk(done == 1'b0 && busy == 1'b0, "R11", "empty mask settles", int'({done, busy}), 0);

    // R2 R7 R1: three blocks, retries, start poked while busy
    need = '{1, 3, 0, 2}; bad = '{0, 2, 0, 3};
    bval = '{16'h0000, 16'hFFFE, 16'h0000, 16'h7FFF};
    run_op(4'b1011, 5, 1'b1);

    // R4 boundary: pulse equal to the watchdog limit
    need = '{1, 1, 1, 1};
    run_op(4'b0001, WDT, 1'b0);

    // R5 watchdog fault on block 1, block 2 skipped
    run_op(4'b0110, WDT + 1, 1'b0);
    repeat (4) step();
    chk(err == 1'b1 && err_wdt == 1'b1, "R12", "fault held", int'({err, err_wdt}), 3);
    chk(err_blk == IDX_W'(1), "R12", "fault block held", int'(err_blk), 1);

    // R8 boundary: exactly the pass limit succeeds
    need = '{1, 1, 1, MP}; bad = '{0, 0, 0, 1}; bval[3] = 16'h00FF;
    run_op(4'b1000, 2, 1'b0);

    // R8 limit exceeded on block 2, block 3 skipped
    need = '{1, 1, MP + 1, 1}; bad = '{0, 0, 3, 0}; bval[2] = 16'hFF7F;
    run_op(4'b1100, 2, 1'b0);

    // random requests
    for (int k = 0; k < 10; k++) begin
      for (int b = 0; b < NB; b++) begin
        need[b] = $urandom_range(0, 4);
        bad[b]  = $urandom_range(0, BW - 1);
        case ($urandom_range(0, 2))
          0:       bval[b] = 16'hFFFE;
          1:       bval[b] = 16'h7FFF;
          default: bval[b] = 16'($urandom_range(0, 16'hFFFE));
        endcase
      end
      run_op(NB'($urandom_range(1, (1 << NB) - 1)), $urandom_range(1, 12), k[0]);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule